// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer/Counter

The block holds two timer/counter channels. Each channel advances on one of two sources. One is a tick that a free-running divider raises once every twelve clocks. The other is a falling edge on the channel's count pin, detected after a two-flop synchronizer. A channel advances only when its run bit is set and its gate condition holds. The gate condition is either "always" or "the channel's synchronized gate pin is high". A two-bit mode field per channel selects one of four modes:
- a 13-bit count made from a 5-bit prescaler below an 8-bit count;
- a full 16-bit count;
- an 8-bit count that reloads from the high byte when it wraps;
- a fourth mode that freezes channel 1, or splits channel 0 into two 8-bit counters.

Each wrap sets the channel's overflow flag, which drives its interrupt request. A wrap of channel 1 also produces a one-cycle pulse for a serial baud generator. Software reaches the registers through a simple write port and a combinational read port. A flag is cleared by writing 0 to it or by a per-channel acknowledge input. The external reset is asynchronous and active low. It is released inside the block through a two-flop synchronizer, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `timer_counter_unit`

## Requirements
- R1: Out of reset, every register reads 0x00, `irq` is 2'b00 and `baud_pulse` is 0.
- R2: Register addresses and fields:
  - address 0 is configuration, where bits [1:0] are the channel 0 mode, bit 2 selects the pin source, bit 3 enables gating, and bits [7:4] repeat this layout for channel 1;
  - address 1 holds run0 in bit 0, run1 in bit 1, flag0 in bit 2 and flag1 in bit 3, with bits [7:4] reading 0;
  - addresses 2 and 3 are the channel 0 low and high bytes, and addresses 4 and 5 are the channel 1 low and high bytes;
  - other addresses read 0.
- R3: With the pin source cleared, a running channel advances once every 12 clocks. With it set, the channel advances on the third rising clock edge after its count pin falls from 1 to 0.
- R4: A channel advances only while its run bit is 1 and either its gating bit is 0 or its gate pin, after synchronization, is 1.
- R5: Mode 0 treats low-byte bits [4:0] as a prescaler. When they are 31, an advance clears them and increments the high byte. Overflow occurs when the high byte wraps from 0xFF. Low-byte bits [7:5] are left unchanged.
- R6: Mode 1 counts {high, low} as a 16-bit value and overflows on the wrap from 0xFFFF to 0x0000.
- R7: Mode 2 increments the low byte. An advance at 0xFF loads the low byte from the high byte and overflows.
- R8: In mode 3, channel 1 holds its count whatever its run bit, gate and source are.
- R9: With channel 0 in mode 3:
  - the channel 0 low byte is an 8-bit counter under channel 0's own controls, and its wrap sets flag0;
  - the channel 0 high byte counts the twelve-clock tick while run1 is 1, and its wrap sets flag1;
  - a channel 1 overflow then no longer sets flag1.
- R10: An overflow sets its flag at the same clock edge, and `irq` equals the two flags. The flag updates follow this priority:
  - a hardware set wins over a write;
  - a write to address 1 loads both flag bits;
  - otherwise, an acknowledge input clears its flag.
- R11: `baud_pulse` is high for exactly the one cycle after each channel 1 overflow, including when channel 0 is in mode 3.
- R12: In a cycle that writes any of addresses 2 to 5, no channel advances and the written byte takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| cnt_pin | input | 2 | Count source pin per channel |
| gate_pin | input | 2 | Gate pin per channel |
| flag_ack | input | 2 | Per-channel flag acknowledge |
| irq | output | 2 | Interrupt requests (overflow flags) |
| baud_pulse | output | 1 | One-cycle channel 1 overflow pulse |

## Verification
The single-cycle baud property assumes that two channel 1 overflows never fall on consecutive cycles. The divider spaces its ticks twelve clocks apart, and the edge detector cannot report falls on consecutive cycles, so this assumption holds for any pin waveform. The hold and acknowledge properties are conditioned on quiet cycles: no count write, and no write to address 1. The random stimulus therefore keeps writes sparse, at about one cycle in sixteen, so those quiet cycles occur often. Pins toggle and acknowledges fire at random rates, with no constraint beyond being driven away from the clock edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int N_CHAN = 2;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_PRE13   = 2'd0,
    MODE_FULL16  = 2'd1,
    MODE_RELOAD8 = 2'd2,
    MODE_SPLIT   = 2'd3
  } tmr_mode_e;

  // Per-channel nibble in the configuration register.
  typedef struct packed {
    logic      gate_en;
    logic      pin_src;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] A_RUNFLG = 3'd1;
  localparam logic [ADDR_W-1:0] A_C0LO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_C0HI   = 3'd3;
  localparam logic [ADDR_W-1:0] A_C1LO   = 3'd4;
  localparam logic [ADDR_W-1:0] A_C1HI   = 3'd5;

endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign fall = prev_q & ~level;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W         = BYTE_W,
  parameter int PRE_BITS  = 5,
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         inc,
  input  logic         inc_split,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_byte,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf,
  output logic         ovf_split
);
  localparam logic [PRE_BITS-1:0] PRE_MAX = {PRE_BITS{1'b1}};
  localparam logic [W-1:0]        BYTE_MAX = {W{1'b1}};

  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [W-1:0] lo_nx, hi_nx;
  logic         ovf_c, ovf_s;

  // Counting next state
  always_comb begin
    lo_nx = lo_q;
    hi_nx = hi_q;
    ovf_c = 1'b0;
    ovf_s = 1'b0;
    unique case (mode)
      MODE_PRE13: begin
        if (inc) begin
          if (lo_q[PRE_BITS-1:0] == PRE_MAX) begin
            lo_nx[PRE_BITS-1:0] = '0;
            hi_nx = hi_q + 1'b1;
            ovf_c = (hi_q == BYTE_MAX);
          end else begin
            lo_nx[PRE_BITS-1:0] = lo_q[PRE_BITS-1:0] + 1'b1;
          end
        end
      end
      MODE_FULL16: begin
        if (inc) begin
          {hi_nx, lo_nx} = {hi_q, lo_q} + 1'b1;
          ovf_c = (hi_q == BYTE_MAX) && (lo_q == BYTE_MAX);
        end
      end
      MODE_RELOAD8: begin
        if (inc) begin
          if (lo_q == BYTE_MAX) begin
            lo_nx = hi_q;
            ovf_c = 1'b1;
          end else begin
            lo_nx = lo_q + 1'b1;
          end
        end
      end
      MODE_SPLIT: begin
        if (HAS_SPLIT) begin
          if (inc) begin
            lo_nx = lo_q + 1'b1;
            ovf_c = (lo_q == BYTE_MAX);
          end
          if (inc_split) begin
            hi_nx = hi_q + 1'b1;
            ovf_s = (hi_q == BYTE_MAX);
          end
        end
      end
      default: ;
    endcase
  end

  // Register writes override the counting result
  always_comb begin
    lo_d = wr_lo ? wr_byte : lo_nx;
    hi_d = wr_hi ? wr_byte : hi_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo        = lo_q;
  assign hi        = hi_q;
  assign ovf       = ovf_c;
  assign ovf_split = ovf_s;
endmodule

// File: rtl/timer_counter_unit.sv
module timer_counter_unit
  import tmr_pkg::*;
#(
  parameter int OSC_DIV     = 12,
  parameter int PRE_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [N_CHAN-1:0] cnt_pin,
  input  logic [N_CHAN-1:0] gate_pin,
  input  logic [N_CHAN-1:0] flag_ack,
  output logic [N_CHAN-1:0] irq,
  output logic              baud_pulse
);
  localparam int CFG_W = $bits(chan_cfg_t);

  // Reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Configuration, run, flag and baud registers
  logic [BYTE_W-1:0] cfg_q, cfg_d;
  logic [N_CHAN-1:0] run_q, run_d;
  logic [N_CHAN-1:0] flag_q, flag_d, flag_set;
  logic              baud_q, baud_d;

  chan_cfg_t         cfg [N_CHAN];
  logic              tick;
  logic [N_CHAN-1:0] cnt_lvl, cnt_fall, gate_lvl;
  logic [N_CHAN-1:0] src, allow, inc, inc_split;
  logic [N_CHAN-1:0] ovf, ovf_split;
  logic [N_CHAN-1:0] wr_lo, wr_hi;
  logic [BYTE_W-1:0] c_lo [N_CHAN];
  logic [BYTE_W-1:0] c_hi [N_CHAN];
  logic              cnt_wr, wr_cfg, wr_runflg, split0;

  tmr_tick_div #(.DIV(OSC_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_int_n),
    .tick (tick)
  );

  tmr_sync #(.WIDTH(N_CHAN), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (cnt_pin),
    .q    (cnt_lvl)
  );

  tmr_fall_det #(.WIDTH(N_CHAN)) u_cnt_fall (
    .clk  (clk),
    .rst_n(rst_int_n),
    .level(cnt_lvl),
    .fall (cnt_fall)
  );

  tmr_sync #(.WIDTH(N_CHAN), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (gate_pin),
    .q    (gate_lvl)
  );

  // Write decode
  always_comb begin
    wr_cfg    = wr_en && (wr_addr == A_CFG);
    wr_runflg = wr_en && (wr_addr == A_RUNFLG);
    cnt_wr    = wr_en && (wr_addr >= A_C0LO) && (wr_addr <= A_C1HI);
  end

  // Per-channel enables and count datapath
  genvar i;
  generate
    for (i = 0; i < N_CHAN; i++) begin : g_ch
      assign cfg[i]   = chan_cfg_t'(cfg_q[i*CFG_W +: CFG_W]);
      assign src[i]   = cfg[i].pin_src ? cnt_fall[i] : tick;
      assign allow[i] = run_q[i] && (!cfg[i].gate_en || gate_lvl[i]);
      assign inc[i]   = src[i] && allow[i] && !cnt_wr;
      assign wr_lo[i] = wr_en && (wr_addr == ADDR_W'(A_C0LO + 2*i));
      assign wr_hi[i] = wr_en && (wr_addr == ADDR_W'(A_C0HI + 2*i));

      if (i == 0) begin : g_split_src
        assign inc_split[i] = tick && run_q[1] && !cnt_wr;
      end else begin : g_no_split_src
        assign inc_split[i] = 1'b0;
      end

      tmr_chan #(
        .W        (BYTE_W),
        .PRE_BITS (PRE_BITS),
        .HAS_SPLIT(i == 0)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .mode     (cfg[i].mode),
        .inc      (inc[i]),
        .inc_split(inc_split[i]),
        .wr_lo    (wr_lo[i]),
        .wr_hi    (wr_hi[i]),
        .wr_byte  (wr_data),
        .lo       (c_lo[i]),
        .hi       (c_hi[i]),
        .ovf      (ovf[i]),
        .ovf_split(ovf_split[i])
      );
    end
  endgenerate

  assign split0 = (cfg[0].mode == MODE_SPLIT);

  // Flag set sources
  always_comb begin
    flag_set[0] = ovf[0];
    flag_set[1] = (ovf[1] && !split0) || ovf_split[0] || ovf_split[1];
  end

  // Next-state for control registers
  always_comb begin
    cfg_d  = wr_cfg ? wr_data : cfg_q;
    baud_d = ovf[1];
    for (int c = 0; c < N_CHAN; c++) begin
      run_d[c] = wr_runflg ? wr_data[c] : run_q[c];
      if (flag_set[c])      flag_d[c] = 1'b1;
      else if (wr_runflg)   flag_d[c] = wr_data[N_CHAN + c];
      else if (flag_ack[c]) flag_d[c] = 1'b0;
      else                  flag_d[c] = flag_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      baud_q <= baud_d;
    end
  end

  // Read port
  always_comb begin
    unique case (rd_addr)
      A_CFG:    rd_data = cfg_q;
      A_RUNFLG: rd_data = {{(BYTE_W - 2*N_CHAN){1'b0}}, flag_q, run_q};
      A_C0LO:   rd_data = c_lo[0];
      A_C0HI:   rd_data = c_hi[0];
      A_C1LO:   rd_data = c_lo[1];
      A_C1HI:   rd_data = c_hi[1];
      default:  rd_data = '0;
    endcase
  end

  assign irq        = flag_q;
  assign baud_pulse = baud_q;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ovf,
  input logic [1:0]  flag,
  input logic [1:0]  run,
  input logic [1:0]  ack,
  input logic        baud,
  input logic        cnt_wr,
  input logic        wr_flag,
  input logic [7:0]  cfg,
  input logic [15:0] c0,
  input logic [15:0] c1
);
  AST_FLAG_SET_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] |=> flag[0]); // R10

  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !ovf[0] && !wr_flag) |=> !flag[0]); // R10

  AST_BAUD_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[1] |=> baud); // R11

  AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud |=> !baud); // R11

  AST_CH1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[5:4] == 2'd3 && !cnt_wr) |=> $stable(c1)); // R8

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && cfg[1:0] != 2'd3 && !cnt_wr) |=> $stable(c0)); // R4

  AST_WRITE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> (ovf == 2'b00)); // R12
endmodule

bind timer_counter_unit tmr_unit_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .ovf    (ovf),
  .flag   (flag_q),
  .run    (run_q),
  .ack    (flag_ack),
  .baud   (baud_q),
  .cnt_wr (cnt_wr),
  .wr_flag(wr_runflg),
  .cfg    (cfg_q),
  .c0     ({c_hi[0], c_lo[0]}),
  .c1     ({c_hi[1], c_lo[1]})
);

// File: tb/tb_timer_counter_unit.sv
module tb_timer_counter_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] flag_ack = '0;
  logic [1:0] irq;
  logic       baud_pulse;

  int n_chk = 0;
  int n_err = 0;
  int baud_seen = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timer_counter_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .flag_ack(flag_ack), .irq(irq), .baud_pulse(baud_pulse)
  );

  // ---------------- reference model ----------------
  logic [1:0] m_rs;
  logic [3:0] m_div;
  logic [1:0] m_s1, m_s2, m_prev, m_g1, m_g2;
  logic [7:0] m_cfg;
  logic [1:0] m_run, m_flag;
  logic [7:0] m_lo [2];
  logic [7:0] m_hi [2];
  logic       m_baud;

  function automatic void adv(input logic [1:0] md, input logic en,
                              inout logic [7:0] lo, inout logic [7:0] hi,
                              output logic ov);
    ov = 1'b0;
    if (!en) return;
    case (md)
      2'd0: if (lo[4:0] == 5'h1F) begin lo[4:0] = 5'h0; ov = (hi == 8'hFF); hi = hi + 8'd1; end
            else lo[4:0] = lo[4:0] + 5'd1;
      2'd1: begin ov = ({hi, lo} == 16'hFFFF); {hi, lo} = {hi, lo} + 16'd1; end
      2'd2: if (lo == 8'hFF) begin lo = hi; ov = 1'b1; end else lo = lo + 8'd1;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_cfg;
      3'd1: return {4'h0, m_flag, m_run};
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic mreset();
    m_div = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_g1 = '0; m_g2 = '0;
    m_cfg = '0; m_run = '0; m_flag = '0; m_baud = 1'b0;
    for (int c = 0; c < 2; c++) begin m_lo[c] = '0; m_hi[c] = '0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 2'b00;
      mreset();
    end else if (!m_rs[1]) begin
      m_rs = {m_rs[0], 1'b1};
      mreset();
    end else begin
      logic tick, cw, o0, o1, os, dummy;
      logic [1:0] en, fl;
      logic [1:0] set;
      tick = (m_div == 4'd11);
      fl = m_prev & ~m_s2;
      cw = wr_en && wr_addr >= 3'd2 && wr_addr <= 3'd5;
      for (int c = 0; c < 2; c++) begin
        logic s, al;
        s  = m_cfg[4*c+2] ? fl[c] : tick;
        al = m_run[c] && (!m_cfg[4*c+3] || m_g2[c]);
        en[c] = s && al && !cw;
      end
      os = 1'b0;
      if (m_cfg[1:0] == 2'd3) begin
        o0 = en[0] && (m_lo[0] == 8'hFF);
        if (en[0]) m_lo[0] = m_lo[0] + 8'd1;
        if (tick && m_run[1] && !cw) begin
          os = (m_hi[0] == 8'hFF);
          m_hi[0] = m_hi[0] + 8'd1;
        end
      end else adv(m_cfg[1:0], en[0], m_lo[0], m_hi[0], o0);
      adv(m_cfg[5:4], en[1], m_lo[1], m_hi[1], o1);
      dummy = 1'b0;
      set[0] = o0;
      set[1] = (o1 && m_cfg[1:0] != 2'd3) || os || dummy;
      for (int c = 0; c < 2; c++) begin
        if (set[c]) m_flag[c] = 1'b1;
        else if (wr_en && wr_addr == 3'd1) m_flag[c] = wr_data[2+c];
        else if (flag_ack[c]) m_flag[c] = 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_cfg = wr_data;
          3'd1: m_run = wr_data[1:0];
          3'd2: m_lo[0] = wr_data;
          3'd3: m_hi[0] = wr_data;
          3'd4: m_lo[1] = wr_data;
          3'd5: m_hi[1] = wr_data;
          default: ;
        endcase
      end
      m_baud = o1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
      m_g2 = m_g1; m_g1 = gate_pin;
      m_div = (m_div == 4'd11) ? 4'd0 : m_div + 4'd1;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && !done) begin
      #1;
      check("R2 model readback", rd_data, mread(rd_addr));
      check("R10 model irq", irq, m_flag);
      check("R11 model baud", baud_pulse, m_baud);
      if (baud_pulse) baud_seen++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a; #2; v = rd_data;
  endtask

  task automatic pulse(input int c);
    @(negedge clk); cnt_pin[c] = 1'b1;
    repeat (3) @(negedge clk);
    cnt_pin[c] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int b0;
    void'($urandom(32'h5EED_0451));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(a[2:0], v); check("R1 reset reg", v, 0); end
    check("R1 reset irq", irq, 0);
    check("R1 reset baud", baud_pulse, 0);

    // R6 / R3 pin source, 16-bit wrap
    wr(3'd0, 8'h05);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    rd(3'd0, v); check("R2 cfg readback", v, 8'h05);
    repeat (3) pulse(0);
    rd(3'd2, v); check("R6 lo after wrap", v, 8'h01);
    rd(3'd3, v); check("R6 hi after wrap", v, 8'h00);
    rd(3'd1, v); check("R10 flag0 set", v, 8'h05);
    check("R10 irq0", irq, 2'b01);

    // R10 acknowledge
    @(negedge clk); flag_ack = 2'b01;
    @(negedge clk); flag_ack = 2'b00;
    rd(3'd1, v); check("R10 ack clears", v, 8'h01);

    // R4 gate pin
    wr(3'd0, 8'h0D);
    repeat (2) pulse(0);
    rd(3'd2, v); check("R4 gate low blocks", v, 8'h01);
    @(negedge clk); gate_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    pulse(0);
    rd(3'd2, v); check("R4 gate high counts", v, 8'h02);
    wr(3'd1, 8'h00);
    pulse(0);
    rd(3'd2, v); check("R4 run off holds", v, 8'h02);

    // R5 prescaled mode
    wr(3'd0, 8'h04);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    pulse(0);
    rd(3'd2, v); check("R5 lo prescaler wrap", v, 8'hE0);
    rd(3'd3, v); check("R5 hi wrap", v, 8'h00);
    rd(3'd1, v); check("R5 flag0", v, 8'h05);
    pulse(0);
    rd(3'd2, v); check("R5 prescaler step", v, 8'hE1);
    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R10 write zero clears", v, 8'h01);

    // R7 / R11 reload mode on channel 1
    wr(3'd0, 8'h60);
    wr(3'd5, 8'hF0); wr(3'd4, 8'hFF); wr(3'd1, 8'h02);
    b0 = baud_seen;
    pulse(1);
    rd(3'd4, v); check("R7 reload lo", v, 8'hF0);
    rd(3'd5, v); check("R7 hi kept", v, 8'hF0);
    rd(3'd1, v); check("R7 flag1", v, 8'h0A);
    check("R11 one baud pulse", baud_seen - b0, 1);
    pulse(1);
    rd(3'd4, v); check("R7 step after reload", v, 8'hF1);

    // R8 channel 1 frozen
    wr(3'd0, 8'h70);
    repeat (2) pulse(1);
    rd(3'd4, v); check("R8 frozen", v, 8'hF1);

    // R12 count write suppresses advance
    wr(3'd0, 8'h50);
    @(negedge clk); cnt_pin[1] = 1'b1;
    repeat (3) @(negedge clk);
    cnt_pin[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd4, v); check("R12 advance suppressed", v, 8'hF1);
    rd(3'd2, v); check("R12 written byte", v, 8'h33);
    pulse(1);
    rd(3'd4, v); check("R12 next advance", v, 8'hF2);

    // R9 split mode
    wr(3'd0, 8'h37);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h03);
    pulse(0);
    repeat (12) @(negedge clk);
    rd(3'd2, v); check("R9 split lo wrap", v, 8'h00);
    rd(3'd1, v); check("R9 both flags", v, 8'h0F);

    // R3 timer source: 120 clocks give 10 advances
    wr(3'd0, 8'h10);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd1, 8'h02);
    repeat (120) @(negedge clk);
    rd(3'd4, v); check("R3 twelve-clock tick", v, 8'h0A);

    // constrained random phase, checked against the model
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      wr_en   = ($urandom % 16) == 0;
      wr_addr = 3'($urandom % 6);
      wr_data = 8'($urandom);
      if (wr_addr == 3'd3 || wr_addr == 3'd5) wr_data[7:4] = 4'hF;
      rd_addr = 3'($urandom % 8);
      if (($urandom % 4) == 0) cnt_pin[0] = ~cnt_pin[0];
      if (($urandom % 3) == 0) cnt_pin[1] = ~cnt_pin[1];
      if (($urandom % 16) == 0) gate_pin = 2'($urandom);
      flag_ack = {($urandom % 32) == 0, ($urandom % 32) == 0};
    end
    @(negedge clk); wr_en = 1'b0; flag_ack = '0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule